// File: doc/BRIEF.md
# Predicated In-Element Reverse Unit

This unit executes one vector reverse instruction per cycle. It takes the 32-bit instruction word, the source vector, the current contents of the destination vector and a per-byte-lane predicate, which the surrounding pipeline has already read from the selected predicate register. Inside every active element it reverses one of four things: the order of the bits, of the bytes, of the 16-bit halfwords or of the 32-bit words. Inactive elements pass the old destination contents through unchanged, so predication merges.

A small decoder pulls the element size, the operation and the three register indices out of the instruction word. It rejects any word whose constant bits do not match, and any operation that is not legal for the chosen element size. A rejected instruction raises the illegal flag and returns the old destination value. The vector length is a parameter and must be a multiple of 64 bits. Results and decoded fields appear one clock after the input is accepted.

Top module: `vrev_unit`

## Requirements
- R1: Operation code 2'b11 (bits 17:16) reverses the bit order inside each element. It is legal for every element size: size code (bits 23:22) 00=8, 01=16, 10=32, 11=64 bits.
- R2: Operation code 2'b00 reverses the byte order inside each element. It is legal for 16, 32 and 64-bit elements. Size code 00 raises the illegal flag.
- R3: Operation code 2'b01 reverses the order of the 16-bit halfwords inside each element. It is legal for 32 and 64-bit elements only. Size codes 00 and 01 raise the illegal flag.
- R4: Operation code 2'b10 reverses the order of the 32-bit words inside each element. It is legal only for 64-bit elements. Any other size raises the illegal flag.
- R5: An element is active when the predicate bit of its lowest-numbered byte lane is 1. The predicate bits of its other byte lanes have no effect. Inactive elements take the old destination value.
- R6: The instruction fields are: destination index in bits 4:0, source index in bits 9:5 and predicate index in bits 12:10. These three are presented on the outputs with the result.
- R7: The constant bits must match: instr & 32'hFF3CE000 equals 32'h05248000. Otherwise the illegal flag is raised. Whenever the illegal flag is raised, the output vector equals the old destination value.
- R8: out_valid equals the previous cycle's in_valid. While in_valid is 0, the output vector and the fields keep their last values.
- R9: After reset, out_valid and out_illegal are 0 and out_vec is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction and operands present this cycle |
| instr | input | 32 | Instruction word |
| src_vec | input | VLEN | Source vector |
| old_vec | input | VLEN | Current destination contents |
| pred | input | VLEN/8 | Governing predicate, one bit per byte lane |
| out_valid | output | 1 | Result valid |
| out_illegal | output | 1 | Instruction was rejected |
| out_vec | output | VLEN | Merged result |
| out_dst | output | 5 | Destination register index |
| out_src | output | 5 | Source register index |
| out_pg | output | 3 | Predicate register index |

## Verification
Every result, flag and field is due exactly one rising edge after the cycle in which in_valid is high; there are no other pipeline stages. The bench drives inputs on the falling edge and samples outputs shortly after the next rising edge. Each check therefore looks at the response to the operation just issued. Idle cycles are checked the same way, one edge after in_valid drops, to confirm that the outputs hold their values.

// File: rtl/vrev_pkg.sv
package vrev_pkg;

  typedef enum logic [1:0] {
    OP_BYTES = 2'b00,
    OP_HALVES = 2'b01,
    OP_WORDS = 2'b10,
    OP_BITS = 2'b11
  } rev_op_e;

  typedef enum logic [1:0] {
    ESZ_8  = 2'b00,
    ESZ_16 = 2'b01,
    ESZ_32 = 2'b10,
    ESZ_64 = 2'b11
  } esz_e;

  localparam logic [31:0] FIXED_MASK = 32'hFF3C_E000;
  localparam logic [31:0] FIXED_VAL  = 32'h0524_8000;

  typedef struct packed {
    rev_op_e    op;
    esz_e       sz;
    logic [2:0] pg;
    logic [4:0] zn;
    logic [4:0] zd;
    logic       illegal;
  } rev_cmd_t;

  // granule width in bits moved as a unit by each operation
  function automatic int unsigned gran_bits(int unsigned op);
    case (op)
      0:       return 8;
      1:       return 16;
      2:       return 32;
      default: return 1;
    endcase
  endfunction

  // legality: the granule must be narrower than the element
  function automatic logic op_legal(rev_op_e op, esz_e sz);
    case (op)
      OP_BITS:   return 1'b1;
      OP_BYTES:  return sz != ESZ_8;
      OP_HALVES: return (sz == ESZ_32) || (sz == ESZ_64);
      default:   return sz == ESZ_64;
    endcase
  endfunction

  // where bit i of the vector lands after reversing granules inside its element
  function automatic int unsigned dest_bit(int unsigned i, int unsigned ebits,
                                           int unsigned gbits);
    int unsigned base, off, g, n;
    base = i - (i % ebits);
    off  = i % ebits;
    g    = off / gbits;
    n    = ebits / gbits;
    return base + (n - 1 - g) * gbits + (off % gbits);
  endfunction

endpackage

// File: rtl/vrev_decode.sv
module vrev_decode
  import vrev_pkg::*;
(
  input  logic [31:0] instr,
  output rev_cmd_t    cmd,
  output logic        fixed_ok
);

  rev_op_e op;
  esz_e    sz;

  assign op       = rev_op_e'(instr[17:16]);
  assign sz       = esz_e'(instr[23:22]);
  assign fixed_ok = (instr & FIXED_MASK) == FIXED_VAL;

  always_comb begin
    cmd.op      = op;
    cmd.sz      = sz;
    cmd.pg      = instr[12:10];
    cmd.zn      = instr[9:5];
    cmd.zd      = instr[4:0];
    cmd.illegal = !fixed_ok || !op_legal(op, sz);
  end

  // R2: byte reversal of 8-bit elements must be rejected
  always_comb begin
    if (instr[17:16] == 2'b00 && instr[23:22] == 2'b00)
      a_r2_byte8_illegal: assert (cmd.illegal);
  end

endmodule

// File: rtl/vrev_permute.sv
module vrev_permute
  import vrev_pkg::*;
#(
  parameter int VLEN = 128
) (
  input  logic [VLEN-1:0] src,
  input  rev_op_e         op,
  input  esz_e            sz,
  output logic [VLEN-1:0] res
);

  localparam int NVAR = 16;

  logic [NVAR-1:0][VLEN-1:0] perm_all;

  for (genvar s = 0; s < 4; s++) begin : g_sz
    for (genvar o = 0; o < 4; o++) begin : g_op
      localparam int unsigned EB = 8 << s;
      localparam int unsigned GB = gran_bits(o);
      if (GB < EB) begin : g_ok
        logic [VLEN-1:0] p;
        for (genvar i = 0; i < VLEN; i++) begin : g_bit
          assign p[dest_bit(i, EB, GB)] = src[i];
        end
        assign perm_all[s*4+o] = p;
      end else begin : g_na
        assign perm_all[s*4+o] = src;
      end
    end
  end

  assign res = perm_all[{sz, op}];

endmodule

// File: rtl/vrev_merge.sv
module vrev_merge
  import vrev_pkg::*;
#(
  parameter int VLEN = 128,
  localparam int NB = VLEN / 8
) (
  input  logic [VLEN-1:0] perm,
  input  logic [VLEN-1:0] old,
  input  logic [NB-1:0]   pred,
  input  esz_e            sz,
  input  logic            illegal,
  output logic [NB-1:0]   byte_act,
  output logic [VLEN-1:0] merged
);

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [3:0] cand;
    assign cand = {pred[b & ~7], pred[b & ~3], pred[b & ~1], pred[b]};
    assign byte_act[b] = cand[sz];
    assign merged[b*8 +: 8] = (byte_act[b] && !illegal) ? perm[b*8 +: 8]
                                                        : old[b*8 +: 8];
  end

endmodule

// File: rtl/vrev_unit.sv
module vrev_unit
  import vrev_pkg::*;
#(
  parameter int VLEN = 128,
  localparam int NB = VLEN / 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     instr,
  input  logic [VLEN-1:0] src_vec,
  input  logic [VLEN-1:0] old_vec,
  input  logic [NB-1:0]   pred,
  output logic            out_valid,
  output logic            out_illegal,
  output logic [VLEN-1:0] out_vec,
  output logic [4:0]      out_dst,
  output logic [4:0]      out_src,
  output logic [2:0]      out_pg
);

  rev_cmd_t        cmd;
  logic            fixed_ok;
  logic [VLEN-1:0] perm_vec;
  logic [VLEN-1:0] merged_vec;
  logic [NB-1:0]   byte_act;

  vrev_decode u_dec (
    .instr    (instr),
    .cmd      (cmd),
    .fixed_ok (fixed_ok)
  );

  vrev_permute #(.VLEN(VLEN)) u_perm (
    .src (src_vec),
    .op  (cmd.op),
    .sz  (cmd.sz),
    .res (perm_vec)
  );

  vrev_merge #(.VLEN(VLEN)) u_merge (
    .perm     (perm_vec),
    .old      (old_vec),
    .pred     (pred),
    .sz       (cmd.sz),
    .illegal  (cmd.illegal),
    .byte_act (byte_act),
    .merged   (merged_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_vec     <= '0;
      out_dst     <= '0;
      out_src     <= '0;
      out_pg      <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_illegal <= cmd.illegal;
        out_vec     <= merged_vec;
        out_dst     <= cmd.zd;
        out_src     <= cmd.zn;
        out_pg      <= cmd.pg;
      end
    end
  end

  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_vec)));

  a_r7_illegal_keeps_old: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !fixed_ok) |=> (out_illegal && out_vec == $past(old_vec)));

  a_r5_no_active_keeps_old: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pred == '0) |=> (out_vec == $past(old_vec)));

  a_r4_word_needs_64: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[17:16] == 2'b10 && instr[23:22] != 2'b11) |=> out_illegal);

  a_r6_fields: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_dst == $past(instr[4:0]) && out_pg == $past(instr[12:10])));

endmodule

// File: tb/sim_vrev_unit.sv
module sim_vrev_unit;

  localparam int VLEN = 128;
  localparam int NB = VLEN / 8;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 20000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [31:0]     instr = '0;
  logic [VLEN-1:0] src_vec = '0;
  logic [VLEN-1:0] old_vec = '0;
  logic [NB-1:0]   pred = '0;
  logic            out_valid, out_illegal;
  logic [VLEN-1:0] out_vec;
  logic [4:0]      out_dst, out_src;
  logic [2:0]      out_pg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vrev_unit #(.VLEN(VLEN)) u0 (
    .clk, .rst_n, .in_valid, .instr, .src_vec, .old_vec, .pred,
    .out_valid, .out_illegal, .out_vec, .out_dst, .out_src, .out_pg
  );

  function automatic logic [31:0] mk(int op, int sz, int pg, int zn, int zd);
    return 32'h0524_8000 | (32'(sz) << 22) | (32'(op) << 16)
         | (32'(pg) << 10) | (32'(zn) << 5) | 32'(zd);
  endfunction

  function automatic bit ref_illegal(logic [31:0] w);
    int op, sz;
    op = int'(w[17:16]);
    sz = int'(w[23:22]);
    if ((w & 32'hFF3C_E000) != 32'h0524_8000) return 1'b1;
    if (op == 0) return sz < 1;
    if (op == 1) return sz < 2;
    if (op == 2) return sz < 3;
    return 1'b0;
  endfunction

  // element-by-element model: copy granule k of each element to slot n-1-k
  function automatic logic [VLEN-1:0] ref_vec(logic [31:0] w, logic [VLEN-1:0] s,
                                              logic [VLEN-1:0] o, logic [NB-1:0] p);
    logic [VLEN-1:0] r;
    int ebytes, ebits, g, n;
    r = o;
    if (ref_illegal(w)) return r;
    ebytes = 1 << int'(w[23:22]);
    ebits  = ebytes * 8;
    case (int'(w[17:16]))
      0: g = 8;
      1: g = 16;
      2: g = 32;
      default: g = 1;
    endcase
    n = ebits / g;
    for (int e = 0; e < VLEN / ebits; e++) begin
      if (p[e * ebytes]) begin
        for (int k = 0; k < n; k++)
          for (int j = 0; j < g; j++)
            r[e*ebits + (n-1-k)*g + j] = s[e*ebits + k*g + j];
      end
    end
    return r;
  endfunction

  function automatic logic [VLEN-1:0] rnd_vec();
    logic [VLEN-1:0] v;
    for (int i = 0; i < VLEN / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic chk_bit(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic chk_vec(string tag, string what, logic [VLEN-1:0] act,
                         logic [VLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic issue(string tag, logic [31:0] w, logic [VLEN-1:0] s,
                       logic [VLEN-1:0] o, logic [NB-1:0] p);
    @(negedge clk);
    in_valid = 1'b1; instr = w; src_vec = s; old_vec = o; pred = p;
    @(posedge clk);
    #1;
    chk_bit("R8", "out_valid", out_valid, 1'b1);
    chk_bit(tag, "illegal", out_illegal, ref_illegal(w));
    chk_vec(tag, "vec", out_vec, ref_vec(w, s, o, p));
  endtask

  function automatic string op_tag(int op);
    case (op)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R1";
    endcase
  endfunction

  initial begin
    logic [VLEN-1:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    chk_bit("R9", "out_valid", out_valid, 1'b0);
    chk_bit("R9", "out_illegal", out_illegal, 1'b0);
    chk_vec("R9", "out_vec", out_vec, '0);
    @(negedge clk);
    rst_n = 1'b1;

    // R6, R1: directed example word, bit reverse 8-bit, pg 7, zn 31, zd 0
    issue("R1", 32'h0527_9FE0, rnd_vec(), rnd_vec(), '1);
    chk_bit("R6", "dst", out_dst == 5'd0, 1'b1);
    chk_bit("R6", "src", out_src == 5'd31, 1'b1);
    chk_bit("R6", "pg", out_pg == 3'd7, 1'b1);
    issue("R6", mk(3, 2, 5, 12, 19), rnd_vec(), rnd_vec(), '1);
    chk_bit("R6", "dst", out_dst == 5'd19, 1'b1);
    chk_bit("R6", "src", out_src == 5'd12, 1'b1);
    chk_bit("R6", "pg", out_pg == 3'd5, 1'b1);

    // R1..R4: every operation at every size, all lanes active
    for (int op = 0; op < 4; op++)
      for (int sz = 0; sz < 4; sz++)
        issue(op_tag(op), mk(op, sz, 1, 2, 3), rnd_vec(), rnd_vec(), '1);

    // R5: only non-lowest lanes of each 64-bit element set -> all inactive
    issue("R5", mk(1, 3, 0, 0, 0), rnd_vec(), rnd_vec(), {NB/8{8'hFE}});
    // R5: only lowest lanes of 32-bit elements set -> all active
    issue("R5", mk(0, 2, 0, 0, 0), rnd_vec(), rnd_vec(), {NB/4{4'h1}});
    issue("R5", mk(3, 1, 0, 0, 0), rnd_vec(), rnd_vec(), '0);
    for (int k = 0; k < 16; k++)
      issue("R5", mk(k % 4, 1 + (k % 3), 0, 0, 0), rnd_vec(), rnd_vec(),
            NB'($urandom));

    // R7: corrupt each constant region
    issue("R7", mk(3, 3, 0, 0, 0) ^ 32'h8000_0000, rnd_vec(), rnd_vec(), '1);
    issue("R7", mk(0, 3, 0, 0, 0) ^ 32'h0004_0000, rnd_vec(), rnd_vec(), '1);
    issue("R7", mk(1, 2, 0, 0, 0) ^ 32'h0000_2000, rnd_vec(), rnd_vec(), '1);

    // R8: idle cycle keeps output
    held = out_vec;
    @(negedge clk);
    in_valid = 1'b0; instr = mk(3, 0, 0, 0, 0); src_vec = rnd_vec();
    old_vec = rnd_vec(); pred = '1;
    @(posedge clk);
    #1;
    chk_bit("R8", "idle out_valid", out_valid, 1'b0);
    chk_vec("R8", "idle hold", out_vec, held);
    @(posedge clk);
    #1;
    chk_vec("R8", "idle hold 2", out_vec, held);

    // random mix
    for (int k = 0; k < 300; k++) begin
      int op, sz;
      logic [31:0] w;
      op = int'($urandom % 4);
      sz = int'($urandom % 4);
      w = mk(op, sz, int'($urandom % 8), int'($urandom % 32), int'($urandom % 32));
      if ($urandom % 16 == 0) w = w ^ (32'h1 << (13 + $urandom % 19));
      issue(ref_illegal(w) ? "R7" : op_tag(op), w, rnd_vec(), rnd_vec(),
            NB'($urandom));
    end

    @(negedge clk);
    in_valid = 1'b0;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule